// File: doc/BRIEF.md
# Capture-to-Playback Monitor Byte Buffer

This block lets audio bytes captured on a serial audio link be sent straight back out on a playback slot without a round trip through host memory. Each audio interface has its own small store of `DEPTH` bytes (four by default). While a superframe of timeslots runs, a capture slot can put its sampled byte into one store position, and a playback slot can take one position as its outgoing byte. The driver places positions so the store holds either two 16-bit channels (positions 0-1 and 2-3) or one 32-bit channel (positions 0-3).

Every slot is marked by a one-cycle strobe. A capture byte can go to a position given with the slot, or to the next position of an internal fill pointer. The fill pointer steps after each pointer-directed write, wraps after the last position, and returns to position 0 after the slot that closes a superframe. Inside one slot the store is read before it is written. A byte captured in a slot therefore reaches playback one slot later at the earliest. A playback slot that reads a position before the capture slot of the same superframe refills it gets the previous superframe's byte, which is one sample of delay.

Top module: `fbl_top`

## Requirements
- R1: After synchronous reset every stored byte is 0x00, every fill pointer is 0 and every `pb_byte` lane is 0x00.
- R2: A slot strobe with `cap_we`=1 and `cap_auto`=0 stores `cap_byte` at position `cap_pos`. A slot strobe with `pb_re`=1 loads the byte at `pb_pos` into `pb_byte`, where it can be seen on the cycle after the strobe. Any position can be read in any order.
- R3: If a strobe writes and reads the same position, `pb_byte` gets the byte held before that slot, and the new byte is returned by a later slot.
- R4: With `cap_we`=1 and `cap_auto`=1 the byte goes to the fill pointer's position. The pointer then steps by one and wraps from DEPTH-1 to 0.
- R5: A strobe with `sf_end`=1 returns the fill pointer to 0 after that slot's own write, which uses the old pointer value.
- R6: Without a strobe, no input changes the store, the pointer or `pb_byte`. A strobe with `pb_re`=0 leaves `pb_byte` unchanged.
- R7: Every interface lane has its own store and pointer. A write on one lane never shows up in another lane's playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | NUM_IF | One-cycle slot strobe for each lane |
| sf_end | input | NUM_IF | This slot closes the superframe (pointer to 0) |
| cap_we | input | NUM_IF | Capture write enable |
| cap_auto | input | NUM_IF | 1: write at fill pointer; 0: write at cap_pos |
| cap_pos | input | NUM_IF*AW | Explicit capture position for each lane |
| cap_byte | input | NUM_IF*BYTE_W | Captured byte for each lane |
| pb_re | input | NUM_IF | Playback read enable |
| pb_pos | input | NUM_IF*AW | Playback read position for each lane |
| pb_byte | output | NUM_IF*BYTE_W | Registered playback byte for each lane |

## Verification
A capture write and a playback read can hit the same store position in the same slot. This is the case that sets whether the loop-back delay is zero or one sample. The bench drives both in one strobe. It expects the old byte on `pb_byte` in the cycle after the strobe, then reads the position again in a later slot and expects the new byte. A pointer-directed write together with the superframe-end flag in the same slot is the second collision. It is judged by where that write lands and by where the next pointer-directed write lands.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
  // Position following p in a store of depth d (wraps to zero).
  function automatic int unsigned fbl_next(input int unsigned p, input int unsigned d);
    return (p == d - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/fbl_ptr.sv
module fbl_ptr #(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          adv,
  input  logic          clr,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (stb) begin
      if (clr) ptr <= '0;
      else if (adv) ptr <= AW'(fbl_pkg::fbl_next(int'(ptr), DEPTH));
    end
  end

  // R5: the superframe end sends the pointer back to position 0
  a_r5_sf_reset: assert property (@(posedge clk) disable iff (rst)
    stb && clr |=> ptr == '0);
  // R6: with no strobe the pointer keeps its value
  a_r6_ptr_idle: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(ptr));
  // R1: reset puts the pointer at position 0
  a_r1_ptr_rst: assert property (@(posedge clk) rst |=> ptr == '0);
endmodule

// File: rtl/fbl_store.sv
module fbl_store #(
  parameter int DEPTH  = 4,
  parameter int BYTE_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              we,
  input  logic [AW-1:0]     wpos,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     rpos,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  // Write port: the new byte is committed at the slot edge
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb && we) begin
      mem[wpos] <= wdata;
    end
  end

  // Registered read port: it samples the contents from before the write (read-first)
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (stb && re) rdata <= mem[rpos];
  end

  // R3: a read and a write to the same position in one slot return the old byte
  a_r3_read_first: assert property (@(posedge clk) disable iff (rst)
    stb && re && we && (wpos == rpos) |=> rdata == $past(mem[rpos]));
  // R6: with no read strobe the output keeps its value
  a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
    !(stb && re) |=> $stable(rdata));
  // R6: with no strobe the store keeps its contents
  a_r6_mem_idle: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(mem[0]) && $stable(mem[DEPTH-1]));
  // R1: reset clears the output
  a_r1_out_rst: assert property (@(posedge clk) rst |=> rdata == '0);
endmodule

// File: rtl/fbl_lane.sv
module fbl_lane #(
  parameter int DEPTH  = 4,
  parameter int BYTE_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              sf_end,
  input  logic              we,
  input  logic              auto_pos,
  input  logic [AW-1:0]     wpos,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     rpos,
  output logic [BYTE_W-1:0] rdata
);
  logic [AW-1:0] fill_ptr;
  logic [AW-1:0] eff_wpos;

  fbl_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .stb(stb),
    .adv(we && auto_pos), .clr(sf_end), .ptr(fill_ptr)
  );

  assign eff_wpos = auto_pos ? fill_ptr : wpos;

  fbl_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst(rst), .stb(stb), .we(we), .wpos(eff_wpos),
    .wdata(wdata), .re(re), .rpos(rpos), .rdata(rdata)
  );

  // R4: a pointer-directed write outside the superframe end moves the pointer
  a_r4_ptr_moves: assert property (@(posedge clk) disable iff (rst)
    stb && we && auto_pos && !sf_end |=> fill_ptr != $past(fill_ptr));
endmodule

// File: rtl/fbl_top.sv
module fbl_top #(
  parameter int NUM_IF = 2,
  parameter int DEPTH  = 4,
  parameter int BYTE_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IF-1:0]        slot_stb,
  input  logic [NUM_IF-1:0]        sf_end,
  input  logic [NUM_IF-1:0]        cap_we,
  input  logic [NUM_IF-1:0]        cap_auto,
  input  logic [NUM_IF*AW-1:0]     cap_pos,
  input  logic [NUM_IF*BYTE_W-1:0] cap_byte,
  input  logic [NUM_IF-1:0]        pb_re,
  input  logic [NUM_IF*AW-1:0]     pb_pos,
  output logic [NUM_IF*BYTE_W-1:0] pb_byte
);
  for (genvar g = 0; g < NUM_IF; g++) begin : g_lane
    fbl_lane #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_lane (
      .clk(clk), .rst(rst),
      .stb(slot_stb[g]), .sf_end(sf_end[g]),
      .we(cap_we[g]), .auto_pos(cap_auto[g]),
      .wpos(cap_pos[g*AW +: AW]), .wdata(cap_byte[g*BYTE_W +: BYTE_W]),
      .re(pb_re[g]), .rpos(pb_pos[g*AW +: AW]),
      .rdata(pb_byte[g*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: tb/tb_fbl_top.sv
module tb_fbl_top;
  localparam int NUM_IF = 2;
  localparam int DEPTH  = 4;
  localparam int BYTE_W = 8;
  localparam int AW     = 2;

  logic clk = 1'b0;
  logic rst;
  logic [NUM_IF-1:0]        slot_stb, sf_end, cap_we, cap_auto, pb_re;
  logic [NUM_IF*AW-1:0]     cap_pos, pb_pos;
  logic [NUM_IF*BYTE_W-1:0] cap_byte;
  logic [NUM_IF*BYTE_W-1:0] pb_byte;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fbl_top #(.NUM_IF(NUM_IF), .DEPTH(DEPTH), .BYTE_W(BYTE_W)) dut (
    .clk(clk), .rst(rst), .slot_stb(slot_stb), .sf_end(sf_end),
    .cap_we(cap_we), .cap_auto(cap_auto), .cap_pos(cap_pos),
    .cap_byte(cap_byte), .pb_re(pb_re), .pb_pos(pb_pos), .pb_byte(pb_byte)
  );

  task automatic check(input int ln, input logic [7:0] exp, input string req);
    n_cmp++;
    if (pb_byte[ln*BYTE_W +: BYTE_W] !== exp) begin
      n_bad++;
      $display("FAIL %s lane %0d: got %02h expected %02h", req, ln,
               pb_byte[ln*BYTE_W +: BYTE_W], exp);
    end
  endtask

  task automatic idle_all();
    slot_stb = '0; sf_end = '0; cap_we = '0; cap_auto = '0; pb_re = '0;
    cap_pos = '0; pb_pos = '0; cap_byte = '0;
  endtask

  // One slot on one lane; outputs can be seen at the following negedge
  task automatic slot(input int ln, input bit we, input bit au, input int wp,
                      input logic [7:0] wb, input bit re, input int rp, input bit last);
    @(negedge clk);
    idle_all();
    slot_stb[ln] = 1'b1; cap_we[ln] = we; cap_auto[ln] = au; sf_end[ln] = last;
    cap_pos[ln*AW +: AW] = AW'(wp); cap_byte[ln*BYTE_W +: BYTE_W] = wb;
    pb_re[ln] = re; pb_pos[ln*AW +: AW] = AW'(rp);
    @(negedge clk);
    idle_all();
  endtask

  task automatic rd(input int ln, input int p, input logic [7:0] exp, input string req);
    slot(ln, 0, 0, 0, 8'h00, 1, p, 0);
    check(ln, exp, req);
  endtask

  task automatic t_reset();
    check(0, 8'h00, "R1");
    check(1, 8'h00, "R1");
    for (int p = 0; p < DEPTH; p++) rd(0, p, 8'h00, "R1");
    rd(1, 2, 8'h00, "R1");
  endtask

  task automatic t_explicit();
    slot(0, 1, 0, 2, 8'h33, 0, 0, 0);
    slot(0, 1, 0, 0, 8'h11, 0, 0, 0);
    slot(0, 1, 0, 3, 8'h44, 0, 0, 0);
    slot(0, 1, 0, 1, 8'h22, 0, 0, 0);
    rd(0, 3, 8'h44, "R2");
    rd(0, 0, 8'h11, "R2");
    rd(0, 2, 8'h33, "R2");
    rd(0, 1, 8'h22, "R2");
  endtask

  task automatic t_same_slot();
    slot(0, 1, 0, 1, 8'h99, 1, 1, 0);
    check(0, 8'h22, "R3 old byte");
    rd(0, 1, 8'h99, "R3 new byte");
  endtask

  task automatic t_auto();
    slot(0, 0, 0, 0, 8'h00, 0, 0, 1);  // pointer to 0
    slot(0, 1, 1, 3, 8'hB0, 0, 0, 0);
    slot(0, 1, 1, 3, 8'hB1, 0, 0, 0);
    slot(0, 1, 1, 0, 8'hB2, 0, 0, 0);
    slot(0, 1, 1, 0, 8'hB3, 0, 0, 0);
    slot(0, 1, 1, 2, 8'hB4, 0, 0, 0);  // wraps to position 0
    rd(0, 0, 8'hB4, "R4 wrap");
    rd(0, 1, 8'hB1, "R4");
    rd(0, 3, 8'hB3, "R4");
  endtask

  task automatic t_sf_end();
    slot(0, 1, 1, 0, 8'hC0, 0, 0, 1);  // lands at pointer 1, then pointer to 0
    slot(0, 1, 1, 3, 8'hC1, 0, 0, 0);  // lands at 0
    rd(0, 1, 8'hC0, "R5 old pointer");
    rd(0, 0, 8'hC1, "R5 restart");
    rd(0, 2, 8'hB2, "R5");
  endtask

  task automatic t_hold();
    rd(0, 0, 8'hC1, "R6");
    @(negedge clk);
    cap_we[0] = 1'b1; cap_auto[0] = 1'b0; cap_byte[7:0] = 8'hEE; pb_re[0] = 1'b1;
    repeat (3) @(negedge clk);
    check(0, 8'hC1, "R6 no strobe");
    idle_all();
    slot(0, 1, 0, 3, 8'h00, 0, 2, 0);  // strobe with no read; write position 3
    check(0, 8'hC1, "R6 no read");
    rd(0, 0, 8'hC1, "R6 store untouched");
    slot(0, 1, 0, 3, 8'hB3, 0, 0, 0);  // put position 3 back
  endtask

  task automatic t_iso();
    slot(1, 1, 0, 3, 8'h5A, 0, 0, 0);
    slot(1, 1, 1, 0, 8'h6B, 0, 0, 0);  // lane 1 pointer at 0
    rd(0, 3, 8'hB3, "R7 lane0 untouched");
    rd(0, 0, 8'hC1, "R7 lane0 untouched");
    rd(1, 3, 8'h5A, "R7 lane1");
    rd(1, 0, 8'h6B, "R7 lane1 own pointer");
    rd(1, 1, 8'h00, "R7 lane1");
  endtask

  initial begin
    idle_all();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_explicit();
    t_same_slot();
    t_auto();
    t_sf_end();
    t_hold();
    t_iso();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule